// File: doc/BRIEF.md
# Arm Capacitor Sort-Select Balancer

This block picks which capacitors of one converter arm go into the power path for the next sampling period. The arm holds N capacitors. They are grouped in pairs, and each pair belongs to one submodule. On a start pulse the block captures three things: the N capacitor voltages, a fault flag for each capacitor, and the requested insertion count. It also captures the sign of the arm current.

The block then ranks the capacitors over N clock cycles. With non-negative current it prefers the least charged capacitors, because they will charge. With negative current it prefers the most charged ones, because they will discharge. A faulty capacitor has its voltage replaced by a value outside the healthy range, so the ranking pushes it to the back.

The result has two parts. The first is a one-hot-per-capacitor insert vector. The second is a 2-bit level count for each submodule, which is the number of its two capacitors that are inserted. The submodule gate decoders downstream read the level counts. Both outputs stay unchanged until the next result is ready.

Top module: `arm_cap_balancer`

## Requirements
- R1: While reset is low and after it is released, `ins`, `lvl`, `done` and `sat` are all zero until the first result is ready.
- R2: `done` is high for exactly one clock cycle. It rises N clock cycles after the rising edge that samples `start` while the block is idle.
- R3: When `done` is high, the number of ones in `ins` equals the requested count, clamped to N. Bit i of `ins` is 1 when capacitor i (zero-based) is inserted.
- R4: With `neg_cur` = 0, the inserted capacitors are the ones with the lowest voltages. Among equal voltages, the lower index is chosen first.
- R5: With `neg_cur` = 1, the inserted capacitors are the ones with the highest voltages. Among equal voltages, the lower index is chosen first.
- R6: A capacitor whose `fault` bit is 1 has its key replaced before ranking. The replacement is twice the arm maximum when `neg_cur` = 0, and half the arm minimum when `neg_cur` = 1. On equal keys, a healthy capacitor ranks ahead of a faulty one. As a result, a faulty capacitor is inserted only when the count exceeds the number of healthy capacitors, and then faulty capacitors are taken in index order.
- R7: Bits [2m+1:2m] of `lvl` give submodule m's level count. It equals `ins[2m] + ins[2m+1]`, so its value is 0, 1 or 2.
- R8: If `want` exceeds N, exactly N capacitors are inserted and `sat` is set to 1. Otherwise `sat` is set to 0. `sat` is updated together with `ins`.
- R9: `ins`, `lvl` and `sat` change only when `done` rises. A `start` while a ranking is in progress is ignored, and so is a change of inputs without `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a ranking with the current inputs |
| volt | input | N*W | Capacitor voltages; capacitor i sits in bits [i*W+W-1:i*W] |
| fault | input | N | Faulty-capacitor flags |
| want | input | $clog2(N)+1 | Requested number of capacitors to insert |
| neg_cur | input | 1 | 1 when the arm current is negative |
| ins | output | N | Insert flags, one per capacitor |
| lvl | output | N | Packed 2-bit level counts, one per submodule |
| done | output | 1 | One-cycle result-valid pulse |
| sat | output | 1 | Requested count was clamped to N |

## Verification
Several properties are checked on every cycle:
- The inserted count matches the clamped request.
- The submodule level counts add up to that same count.
- The done pulse lasts a single cycle.
- The outputs hold between results.
- A faulty capacitor is never inserted while enough healthy ones remain.

Two behaviours can only be shown by the bench's sweeps against an independent selection model:
- that the right capacitors were chosen, including the ordering for each current sign and the lower-index tie rule;
- the exact latency, and that a start arriving during a ranking is ignored.

// File: rtl/arm_cap_balancer.sv
module arm_cap_balancer #(
  parameter int N  = 8,
  parameter int W  = 16,
  localparam int KW = $clog2(N) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*W-1:0] volt,
  input  logic [N-1:0]   fault,
  input  logic [KW-1:0]  want,
  input  logic           neg_cur,
  output logic [N-1:0]   ins,
  output logic [N-1:0]   lvl,
  output logic           done,
  output logic           sat
);
  localparam int IW = $clog2(N);
  localparam int KEYW = W + 1;

  logic            busy, dir, sat_nx;
  logic [IW-1:0]   step;
  logic [KW-1:0]   kreg;
  logic [N-1:0]    flt, ahead;
  logic [KEYW-1:0] key    [N];
  logic [KEYW-1:0] key_in [N];
  logic [KW-1:0]   rank   [N];
  logic [W-1:0]    vmax, vmin;
  logic [KEYW-1:0] kj;
  logic            fj;

  always_comb begin
    vmax = '0;
    vmin = '1;
    for (int i = 0; i < N; i++) begin
      if (volt[i*W +: W] > vmax) vmax = volt[i*W +: W];
      if (volt[i*W +: W] < vmin) vmin = volt[i*W +: W];
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (!fault[i])    key_in[i] = {1'b0, volt[i*W +: W]};
      else if (neg_cur) key_in[i] = {1'b0, vmin} >> 1;
      else              key_in[i] = {vmax, 1'b0};
    end
  end

  assign kj = key[step];
  assign fj = flt[step];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (int'(step) == i)        ahead[i] = 1'b0;
      else if (kj != key[i])      ahead[i] = dir ? (kj > key[i]) : (kj < key[i]);
      else if (fj != flt[i])      ahead[i] = flt[i];
      else                        ahead[i] = int'(step) < i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; dir <= 1'b0; sat_nx <= 1'b0; step <= '0; kreg <= '0;
      flt <= '0; ins <= '0; done <= 1'b0; sat <= 1'b0;
      for (int i = 0; i < N; i++) begin
        key[i]  <= '0;
        rank[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        step   <= '0;
        dir    <= neg_cur;
        flt    <= fault;
        sat_nx <= want > KW'(N);
        kreg   <= (want > KW'(N)) ? KW'(N) : want;
        for (int i = 0; i < N; i++) begin
          key[i]  <= key_in[i];
          rank[i] <= '0;
        end
      end else if (busy) begin
        step <= step + 1'b1;
        for (int i = 0; i < N; i++) rank[i] <= rank[i] + KW'(ahead[i]);
        if (step == IW'(N - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          sat  <= sat_nx;
          for (int i = 0; i < N; i++) ins[i] <= (rank[i] + KW'(ahead[i])) < kreg;
        end
      end
    end
  end

  for (genvar m = 0; m < N / 2; m++) begin : g_lvl
    assign lvl[2*m+1:2*m] = {ins[2*m] & ins[2*m+1], ins[2*m] ^ ins[2*m+1]};
  end

  int lvl_sum;
  always_comb begin
    lvl_sum = 0;
    for (int m = 0; m < N / 2; m++) lvl_sum += int'(lvl[2*m +: 2]);
  end

  // R3
  ins_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones(ins) == int'(kreg));
  // R7
  lvl_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lvl_sum == $countones(ins));
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(ins) && $stable(sat)));
  // R8
  sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sat) |-> int'(kreg) == N);
  // R6
  no_fault_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $countones(~flt) >= int'(kreg)) |-> (ins & flt) == '0);
endmodule

// File: tb/sim_arm_cap_balancer.sv
module sim_arm_cap_balancer;
  localparam int N = 8;
  localparam int W = 16;
  localparam int KW = $clog2(N) + 1;

  logic clk = 0, rst_n = 0, start = 0, neg_cur = 0;
  logic [N*W-1:0] volt = '0;
  logic [N-1:0] fault = '0;
  logic [KW-1:0] want = '0;
  logic [N-1:0] ins, lvl;
  logic done, sat;
  int total = 0, bad = 0, cyc = 0;
  logic [31:0] lf = 32'h1234_5678;

  arm_cap_balancer #(.N(N), .W(W)) u0 (.clk, .rst_n, .start, .volt, .fault,
    .want, .neg_cur, .ins, .lvl, .done, .sat);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL R2 watchdog expired actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] rnd();
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    return lf;
  endfunction

  function automatic logic [N-1:0] model(input logic [N*W-1:0] v, input logic [N-1:0] f,
                                         input int k, input logic ng);
    logic [N-1:0] s = '0;
    int kk = (k > N) ? N : k;
    for (int p = 0; p < kk; p++) begin
      int best = -1;
      for (int i = 0; i < N; i++)
        if (!s[i] && !f[i]) begin
          if (best < 0) best = i;
          else if (ng ? (v[i*W +: W] > v[best*W +: W]) : (v[i*W +: W] < v[best*W +: W])) best = i;
        end
      if (best < 0)
        for (int i = N - 1; i >= 0; i--) if (!s[i] && f[i]) best = i;
      s[best] = 1'b1;
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [N*W-1:0] v, input logic [N-1:0] f, input int k,
                     input logic ng, input bit disturb);
    logic [N-1:0] e = model(v, f, k, ng);
    int c = 0;
    string tg = (f != 0) ? "R6" : (ng ? "R5" : "R4");
    volt = v; fault = f; want = KW'(k); neg_cur = ng; start = 1;
    @(negedge clk); start = 0;
    while (!done && c < 40) begin
      @(negedge clk); c++;
      if (disturb && c == 3) begin
        volt = ~v; fault = ~f; neg_cur = ~ng; want = KW'(N - k); start = 1;
      end else start = 0;
    end
    start = 0;
    chk(c == N, "R2 latency", c, N);
    chk(ins == e, disturb ? "R9 busy start" : tg, int'(ins), int'(e));
    chk($countones(ins) == ((k > N) ? N : k), "R3 count", $countones(ins), (k > N) ? N : k);
    for (int m = 0; m < N / 2; m++)
      chk(int'(lvl[2*m +: 2]) == int'(e[2*m]) + int'(e[2*m+1]), "R7 level",
          int'(lvl[2*m +: 2]), int'(e[2*m]) + int'(e[2*m+1]));
    chk(sat == (k > N), "R8 sat", int'(sat), int'(k > N));
    @(negedge clk);
    chk(!done, "R2 pulse width", int'(done), 0);
  endtask

  initial begin
    logic [N*W-1:0] v;
    logic [N-1:0] f, held;
    repeat (3) @(negedge clk);
    chk(ins == 0 && lvl == 0 && !done && !sat, "R1 in reset", int'({ins, done, sat}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(ins == 0 && lvl == 0 && !done && !sat, "R1 after reset", int'({ins, done, sat}), 0);
    for (int mode = 0; mode < 4; mode++)
      for (int fm = 0; fm < 3; fm++)
        for (int k = 0; k <= 10; k++)
          for (int ng = 0; ng < 2; ng++) begin
            for (int i = 0; i < N; i++) begin
              case (mode)
                0: v[i*W +: W] = rnd()[W-1:0];
                1: v[i*W +: W] = W'(rnd()[1:0] * 100);
                2: v[i*W +: W] = W'(777);
                default: v[i*W +: W] = '0;
              endcase
            end
            f = (fm == 0) ? '0 : (fm == 1) ? N'(1 << (rnd() % N)) : rnd()[N-1:0];
            run(v, f, k, ng[0], 1'b0);
          end
    v = '0;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(1000 - 37 * i);
    run(v, 8'b0001_0010, 5, 1'b0, 1'b1);
    run(v, '0, 3, 1'b1, 1'b1);
    held = ins;
    volt = ~v; fault = '1; want = KW'(N); neg_cur = 1'b0;
    repeat (6) @(negedge clk);
    chk(ins == held && !done, "R9 no start", int'(ins), int'(held));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule